// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Vectors

This controller gathers a set of level-sensitive hardware request lines, a fast-interrupt request and a software trap request, and offers one of them at a time to a processor core. It uses one request output and one acknowledge input. When the core acknowledges, the controller picks the highest-ranked eligible source. One cycle later it returns that source's vector number with a one-cycle valid pulse. At the same moment it raises a flag that says whether the core need save only its program counter, which is the case for a fast interrupt.

The controller records which priority levels are being serviced in an in-service mask. A request is eligible only if its level is strictly above the highest level still in service, so only a more urgent source can preempt a running service routine. Equal and lower requests wait. A return strobe from the core closes the most urgent active service, and waiting requests are then considered again. Optionally, a hardware line's vector can be taken from a device-driven data bus instead of being the line number.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the in-service mask is empty, the acknowledge-valid pulse and fast flag are 0 and the vector is 0. With no request line high, the request output is 0.
- R2: Hardware line N (1..7) has level N and vector N. The request output follows the eligible requests in the same cycle. An accepted acknowledge gives the vector and a valid pulse on the next clock edge.
- R3: When several eligible requests are pending together, the highest level wins. Levels rank as software trap = 0, hardware lines 1..7, fast interrupt = 8.
- R4: While level L is in service, a request above L raises the request output in the same cycle. Its acknowledge gives that source's vector.
- R5: While level L is in service, requests at level L or below do not raise the request output. This holds even if they stay high.
- R6: A return strobe clears only the highest set in-service bit. Eligibility is then judged against the next highest remaining bit.
- R7: The fast interrupt ranks above line 7 and gives vector 8. Its valid pulse carries the program-counter-only flag = 1. Every other source gives the flag as 0.
- R8: The software trap has level 0 and vector 0. It loses to any hardware line, and any hardware line preempts it.
- R9: When the device-vector enable is 1 at the accepted acknowledge and the winner is a hardware line, the vector is the data-bus value. The software trap and fast interrupt keep vectors 0 and 8.
- R10: An acknowledge is accepted only while the request output is 1 and no return strobe is given in the same cycle. Otherwise it produces no valid pulse and changes no nesting state.
- R11: The valid pulse lasts one cycle for each accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | 7 | Hardware request lines; bit k-1 is line k |
| fast_irq | input | 1 | Fast-interrupt request |
| soft_irq | input | 1 | Software trap request |
| dev_vec_en | input | 1 | Take hardware vectors from the data bus |
| dev_bus | input | 8 | Device-supplied vector |
| int_req | output | 1 | Interrupt request to the core |
| int_ack | input | 1 | Core acknowledge |
| svc_ret | input | 1 | End-of-service strobe from the core |
| vec_out | output | 8 | Vector of the accepted source |
| vec_vld | output | 1 | One-cycle pulse qualifying vec_out |
| pc_only | output | 1 | Fast class: save program counter only |

## Verification
The hardest state to reach from the ports is a stack of two nested services. In that state one return must expose the older, lower level, which still blocks some requests and admits others. The bench gets there by taking line 3, preempting it with line 6, and then holding lines 5 and 2 high. After one return, line 5 must be offered and line 2 must not. Line 3 is also kept high throughout, so equal-level blocking is seen as well. A further case gives an acknowledge and a return strobe in the same cycle and shows that the nesting stack is left untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // index of the highest set bit; 0 when none is set
  function automatic int unsigned top_bit(logic [31:0] m);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++)
      if (m[i]) r = i;
    return r;
  endfunction

  // vector chosen for a winning level
  function automatic logic [31:0] level_vector(int unsigned lvl, int unsigned fast_lvl,
                                               logic dev_en, logic [31:0] bus);
    if (dev_en && lvl != 0 && lvl != fast_lvl) return bus;
    return 32'(lvl);
  endfunction
endpackage

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int NLV = 9,
  localparam int LW = $clog2(NLV)
) (
  input  logic [NLV-1:0] pend,
  input  logic [NLV-1:0] isr,
  output logic           elig_any,
  output logic [LW-1:0]  win_lvl
);
  import intc_pkg::*;

  logic          busy;
  logic [LW-1:0] cur_lvl;
  logic [NLV-1:0] elig;

  assign busy    = |isr;
  assign cur_lvl = LW'(top_bit(32'(isr)));

  for (genvar i = 0; i < NLV; i++) begin : g_elig
    assign elig[i] = pend[i] & (!busy || (LW'(i) > cur_lvl));
  end

  assign elig_any = |elig;
  assign win_lvl  = LW'(top_bit(32'(elig)));
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int NLV = 9,
  localparam int LW = $clog2(NLV)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [LW-1:0]  win_lvl,
  input  logic           ret,
  output logic [NLV-1:0] isr
);
  import intc_pkg::*;

  logic [LW-1:0] pop_lvl;
  assign pop_lvl = LW'(top_bit(32'(isr)));

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else if (ret) begin
      if (|isr) isr[pop_lvl] <= 1'b0;
    end else if (take) isr[win_lvl] <= 1'b1;
  end

  p_take_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $countones(isr) == $past($countones(isr)) + 1);
  p_ret_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && |isr) |=> $countones(isr) + 1 == $past($countones(isr)));
endmodule

// File: rtl/intc_vecout.sv
module intc_vecout #(
  parameter int NLV   = 9,
  parameter int VEC_W = 8,
  localparam int LW   = $clog2(NLV),
  localparam int FAST_LVL = NLV - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LW-1:0]    win_lvl,
  input  logic             dev_en,
  input  logic [VEC_W-1:0] dev_bus,
  output logic [VEC_W-1:0] vec,
  output logic             vld,
  output logic             fast
);
  import intc_pkg::*;

  logic [VEC_W-1:0] next_vec;
  assign next_vec = VEC_W'(level_vector(int'(win_lvl), FAST_LVL, dev_en, 32'(dev_bus)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec  <= '0;
      vld  <= 1'b0;
      fast <= 1'b0;
    end else begin
      vld  <= take;
      fast <= take && (int'(win_lvl) == FAST_LVL);
      if (take) vec <= next_vec;
    end
  end

  p_fast_with_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast |-> vld);
  p_vld_caused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(take));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int N_HW  = 7,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_HW-1:0]  hw_irq,
  input  logic             fast_irq,
  input  logic             soft_irq,
  input  logic             dev_vec_en,
  input  logic [VEC_W-1:0] dev_bus,
  output logic             int_req,
  input  logic             int_ack,
  input  logic             svc_ret,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_vld,
  output logic             pc_only
);
  localparam int NLV = N_HW + 2;
  localparam int LW  = $clog2(NLV);

  logic [NLV-1:0] pend;
  logic [NLV-1:0] isr;
  logic [LW-1:0]  win_lvl;
  logic           elig_any;
  logic           take_evt;

  assign pend     = {fast_irq, hw_irq, soft_irq};
  assign int_req  = elig_any;
  assign take_evt = int_ack && elig_any && !svc_ret;

  intc_prio #(.NLV(NLV)) u_prio (
    .pend(pend), .isr(isr), .elig_any(elig_any), .win_lvl(win_lvl)
  );

  intc_nest #(.NLV(NLV)) u_nest (
    .clk(clk), .rst_n(rst_n), .take(take_evt), .win_lvl(win_lvl),
    .ret(svc_ret), .isr(isr)
  );

  intc_vecout #(.NLV(NLV), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .take(take_evt), .win_lvl(win_lvl),
    .dev_en(dev_vec_en), .dev_bus(dev_bus),
    .vec(vec_out), .vld(vec_vld), .fast(pc_only)
  );

  p_noreq_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |=> !vec_vld);
endmodule

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] hw_irq = '0;
  logic       fast_irq = 0, soft_irq = 0, dev_vec_en = 0;
  logic [7:0] dev_bus = '0;
  logic       int_ack = 0, svc_ret = 0;
  logic       int_req, vec_vld, pc_only;
  logic [7:0] vec_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prio_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .fast_irq(fast_irq),
    .soft_irq(soft_irq), .dev_vec_en(dev_vec_en), .dev_bus(dev_bus),
    .int_req(int_req), .int_ack(int_ack), .svc_ret(svc_ret),
    .vec_out(vec_out), .vec_vld(vec_vld), .pc_only(pc_only)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // acknowledge, then check the vector/flag pulse the next edge produces
  task automatic ack_expect(string req, logic [7:0] v, logic f);
    int_ack = 1; tick(); int_ack = 0;
    check(req, vec_vld, 1); check(req, vec_out, v); check(req, pc_only, f);
    tick();
    check({req, "/R11 pulse"}, vec_vld, 0);
  endtask

  task automatic do_ret();
    svc_ret = 1; tick(); svc_ret = 0;
  endtask

  task automatic t_reset();
    check("R1 req", int_req, 0); check("R1 vld", vec_vld, 0);
    check("R1 vec", vec_out, 0); check("R1 fast", pc_only, 0);
    hw_irq[0] = 1; #1;
    check("R1 empty isr", int_req, 1);
    hw_irq = '0; #1;
  endtask

  task automatic t_single();
    hw_irq[4] = 1; #1;
    check("R2 req", int_req, 1);
    ack_expect("R2 line5", 8'd5, 0);
    hw_irq = '0; do_ret();
  endtask

  task automatic t_tie();
    hw_irq[1] = 1; hw_irq[3] = 1; hw_irq[5] = 1; soft_irq = 1; #1;
    ack_expect("R3 tie", 8'd6, 0);
    check("R5 lower held", int_req, 0);
    hw_irq[5] = 0; do_ret();
    check("R3 next", int_req, 1);
    ack_expect("R3 second", 8'd4, 0);
    hw_irq = '0; soft_irq = 0; do_ret();
  endtask

  task automatic t_preempt();
    hw_irq[2] = 1; #1;
    ack_expect("R2 line3", 8'd3, 0);
    check("R5 equal held", int_req, 0);
    hw_irq[5] = 1; #1;
    check("R4 immediate", int_req, 1);
    ack_expect("R4 line6", 8'd6, 0);
    hw_irq[5] = 0; hw_irq[4] = 1; hw_irq[1] = 1; #1;
    check("R5 blocked under 6", int_req, 0);
    do_ret();
    check("R6 5 above 3", int_req, 1);
    ack_expect("R6 line5", 8'd5, 0);
    hw_irq[4] = 0; #1;
    do_ret();
    check("R6 2 blocked by 3", int_req, 0);
    hw_irq[2] = 0; do_ret();
    check("R6 all returned", int_req, 1);
    ack_expect("R6 line2", 8'd2, 0);
    hw_irq = '0; do_ret();
  endtask

  task automatic t_fast();
    hw_irq[6] = 1; #1;
    ack_expect("R7 line7", 8'd7, 0);
    fast_irq = 1; #1;
    check("R7 above 7", int_req, 1);
    ack_expect("R7 fast", 8'd8, 1);
    fast_irq = 0; hw_irq = '0; do_ret(); do_ret();
    check("R7 drained", int_req, 0);
  endtask

  task automatic t_soft();
    soft_irq = 1; #1;
    ack_expect("R8 soft", 8'd0, 0);
    hw_irq[0] = 1; #1;
    check("R8 preempt", int_req, 1);
    ack_expect("R8 line1", 8'd1, 0);
    soft_irq = 0; hw_irq = '0; do_ret(); do_ret();
  endtask

  task automatic t_devvec();
    dev_vec_en = 1; dev_bus = 8'hA5; hw_irq[3] = 1; #1;
    ack_expect("R9 bus", 8'hA5, 0);
    fast_irq = 1; #1;
    ack_expect("R9 fast own", 8'd8, 1);
    fast_irq = 0; hw_irq = '0; do_ret(); do_ret();
    soft_irq = 1; #1;
    ack_expect("R9 soft own", 8'd0, 0);
    soft_irq = 0; dev_vec_en = 0; do_ret();
  endtask

  task automatic t_ignored();
    int_ack = 1; tick(); int_ack = 0;
    check("R10 no req", vec_vld, 0);
    hw_irq[1] = 1; #1;
    int_ack = 1; svc_ret = 1; tick(); int_ack = 0; svc_ret = 0;
    check("R10 with ret", vec_vld, 0);
    check("R10 state kept", int_req, 1);
    ack_expect("R10 later", 8'd2, 0);
    hw_irq[6] = 1; #1;
    check("R10 only 2 active", int_req, 1);
    hw_irq = '0; do_ret();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset(); t_single(); t_tie(); t_preempt();
    t_fast(); t_soft(); t_devvec(); t_ignored();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule